// File: doc/BRIEF.md
# Serial Quad Output-Code Port

This block is the device-side control logic for a three-wire serial port that sets four 8-bit output codes. A host drives a serial clock, a select line and a data line; the block answers on a data-out line with an enable, so a pad or a shared bus driver can float it. Each frame carries a start bit, a two-bit channel number and an eight-bit code. As the new code is shifted in, the code the channel held before is shifted out, so every write is also a destructive read.

The four codes held here are working values. A higher-level programming sequencer owns a set of stored codes and presents them on `stored_codes`. Whenever the select line is low, and right after reset, all four working codes follow the stored set, so any temporary value is thrown away. Short low glitches on select are filtered out. When a frame completes, the block pulses `frame_done` together with the channel and new code, so the sequencer can commit that value if it chooses.

All three serial inputs are synchronized into the system clock `clk`. Serial clock rising edges are detected in that domain, so the serial clock must run well below `clk`.

Top module: `qdac_serial_port`

## Requirements
- R1: A frame opens with a 1 sampled on a rising serial clock edge. The next edges carry A0, A1 and then D0 through D7, least significant bit first. Any 0 sampled while the block waits for a start bit is ignored.
- R2: The channel index is A0 + 2*A1. Channel k occupies `out_codes[8*k +: 8]`, so A0=0,A1=0 selects slice 0, A0=1,A1=0 selects slice 1, A0=0,A1=1 selects slice 2 and A0=1,A1=1 selects slice 3.
- R3: `ser_dout_en` is high only while the filtered select is high. Whenever `ser_dout_en` is low, `ser_dout` is 0.
- R4: After the A1 edge, `ser_dout` shows bit 0 of the addressed channel's code as it stood before the frame. Each following rising edge advances it by one bit, up to bit 7.
- R5: The addressed channel's code takes its new value right after the D7 edge is detected, and no other channel changes at that point. In that same cycle `frame_done` is high for exactly one `clk` cycle, with `frame_addr` and `frame_data` showing the channel and its new code.
- R6: Once select has been low for GLITCH_LEN consecutive synchronized samples, all four codes equal `stored_codes` one cycle later. They keep following it until select returns high.
- R7: A select low pulse shorter than GLITCH_LEN samples neither reloads nor disturbs the working codes.
- R8: The two rising serial clock edges after D7 are ignored, so a 1 sampled on either of them does not open a frame.
- R9: While select stays high, any channel may be rewritten any number of times in any order. Codes change only on frame completion.
- R10: After reset is released, the codes equal `stored_codes` without any serial clock activity.
- R11: If select is dropped in the middle of a frame, that frame is abandoned. After select is raised again, the next start bit begins a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host (asynchronous) |
| ser_sel | input | 1 | Serial select, high = selected (asynchronous) |
| ser_din | input | 1 | Serial data in (asynchronous) |
| stored_codes | input | NCH*CW | Stored code set from the programming sequencer, channel k at [CW*k +: CW] |
| ser_dout | output | 1 | Serial data out |
| ser_dout_en | output | 1 | Output enable for the data-out driver |
| out_codes | output | NCH*CW | Working output codes, channel k at [CW*k +: CW] |
| frame_done | output | 1 | One-cycle strobe when a frame completes |
| frame_addr | output | AW | Channel of the completed frame |
| frame_data | output | CW | New code of the completed frame |

## Verification
The bench uses the default build: four channels, 8-bit codes, a two-stage synchronizer and a select filter of four samples. The serial clock runs at one sixteenth of `clk`. With that short filter, a two-cycle select glitch falls just inside what the filter swallows, while a twenty-cycle low easily trips a reload. That makes both sides of the filter threshold and the mid-frame abandon path reachable within a few frames.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [1:0] {
        PH_HUNT = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_GAP  = 2'd3
    } qdac_phase_e;

    localparam int GAP_EDGES = 2;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_in;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign d_out = pipe_q[STAGES-1];
endmodule

// File: rtl/qdac_sel_filter.sv
module qdac_sel_filter #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_raw,
    output logic sel_ok
);
    localparam int CW_F = $clog2(LEN + 1);

    typedef struct packed {
        logic [CW_F-1:0] low_cnt;
        logic            ok;
    } filt_t;

    filt_t d, q;

    always_comb begin
        d = q;
        if (sel_raw) begin
            d.low_cnt = '0;
            d.ok      = 1'b1;
        end else if (q.low_cnt == CW_F'(LEN - 1)) begin
            d.ok      = 1'b0;
        end else begin
            d.low_cnt = q.low_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sel_ok = q.ok;
endmodule

// File: rtl/qdac_serial_port.sv
module qdac_serial_port
    import qdac_pkg::*;
#(
    parameter  int NCH         = 4,
    parameter  int CW          = 8,
    parameter  int SYNC_STAGES = 2,
    parameter  int GLITCH_LEN  = 4,
    localparam int AW          = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_sel,
    input  logic              ser_din,
    input  logic [NCH*CW-1:0] stored_codes,
    output logic              ser_dout,
    output logic              ser_dout_en,
    output logic [NCH*CW-1:0] out_codes,
    output logic              frame_done,
    output logic [AW-1:0]     frame_addr,
    output logic [CW-1:0]     frame_data
);
    localparam int CNT_W = $clog2(CW + 1);

    typedef logic [NCH-1:0][CW-1:0] bank_t;

    typedef struct packed {
        qdac_phase_e      phase;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    addr;
        logic [CW-1:0]    shreg;
        logic             sclk_prev;
        bank_t            work;
        logic             done;
    } port_t;

    logic [2:0] sync_v;
    logic       sclk_s, sel_s, din_s, sel_ok, rise;
    logic [AW-1:0] a_nxt;
    port_t d, q;

    qdac_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ser_clk, ser_sel, ser_din}),
        .d_out (sync_v)
    );

    assign {sclk_s, sel_s, din_s} = sync_v;

    qdac_sel_filter #(.LEN(GLITCH_LEN)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_raw (sel_s),
        .sel_ok  (sel_ok)
    );

    assign rise = sclk_s & ~q.sclk_prev;

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.sclk_prev = sclk_s;
        a_nxt       = q.addr;
        a_nxt[q.cnt[AW-1:0]] = din_s;
        if (!sel_ok) begin
            d.phase = PH_HUNT;
            d.cnt   = '0;
            d.work  = bank_t'(stored_codes);
        end else if (rise) begin
            unique case (q.phase)
                PH_HUNT: begin
                    if (din_s) begin
                        d.phase = PH_ADDR;
                        d.cnt   = '0;
                    end
                end
                PH_ADDR: begin
                    d.addr = a_nxt;
                    if (q.cnt == CNT_W'(AW - 1)) begin
                        d.phase = PH_DATA;
                        d.cnt   = '0;
                        d.shreg = q.work[a_nxt];
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    d.shreg = {din_s, q.shreg[CW-1:1]};
                    if (q.cnt == CNT_W'(CW - 1)) begin
                        d.work[q.addr] = d.shreg;
                        d.done         = 1'b1;
                        d.phase        = PH_GAP;
                        d.cnt          = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                PH_GAP: begin
                    if (q.cnt == CNT_W'(GAP_EDGES - 1)) begin
                        d.phase = PH_HUNT;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.phase = PH_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ser_dout_en = sel_ok;
    assign ser_dout    = sel_ok & (q.phase == PH_DATA) & q.shreg[0];
    assign out_codes   = q.work;
    assign frame_done  = q.done;
    assign frame_addr  = q.addr;
    assign frame_data  = q.work[q.addr];
endmodule

// File: rtl/qdac_serial_port_chk.sv
module qdac_serial_port_chk #(
    parameter int NCH = 4,
    parameter int CW  = 8,
    parameter int AW  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_dout,
    input logic              ser_dout_en,
    input logic [NCH*CW-1:0] stored_codes,
    input logic [NCH*CW-1:0] out_codes,
    input logic              frame_done,
    input logic [AW-1:0]     frame_addr
);
    p_dout_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_dout_en |-> !ser_dout);

    p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_dout_en |=> (out_codes == $past(stored_codes)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_dout_en && $past(ser_dout_en) && !frame_done) |-> $stable(out_codes));

    for (genvar c = 0; c < NCH; c++) begin : g_iso
        p_isolate_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_done && frame_addr != AW'(c)) |-> $stable(out_codes[c*CW +: CW]));
    end
endmodule

bind qdac_serial_port qdac_serial_port_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_dout     (ser_dout),
    .ser_dout_en  (ser_dout_en),
    .stored_codes (stored_codes),
    .out_codes    (out_codes),
    .frame_done   (frame_done),
    .frame_addr   (frame_addr)
);

// File: tb/qdac_serial_port_bench.sv
`timescale 1ns/1ps
module qdac_serial_port_bench;
    localparam int NCH  = 4;
    localparam int CW   = 8;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_sel = 1'b0, ser_din = 1'b0;
    logic [NCH*CW-1:0] stored_codes;
    logic ser_dout, ser_dout_en, frame_done;
    logic [NCH*CW-1:0] out_codes;
    logic [1:0] frame_addr;
    logic [CW-1:0] frame_data;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [CW-1:0] model [NCH];
    logic [CW-1:0] stored [NCH];
    logic [9:0] exp_q [$];

    always #2.5 clk = ~clk;

    assign stored_codes = {stored[3], stored[2], stored[1], stored[0]};

    qdac_serial_port u_qdac_serial_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel(ser_sel),
        .ser_din(ser_din), .stored_codes(stored_codes), .ser_dout(ser_dout),
        .ser_dout_en(ser_dout_en), .out_codes(out_codes), .frame_done(frame_done),
        .frame_addr(frame_addr), .frame_data(frame_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_codes(input string req);
        for (int k = 0; k < NCH; k++) check(req, 64'(out_codes[k*CW +: CW]), 64'(model[k]));
    endtask

    task automatic pulse(input logic b);
        ser_din = b;
        repeat (HALF) @(posedge clk);
        ser_clk = 1'b1;
        repeat (HALF) @(posedge clk);
        ser_clk = 1'b0;
    endtask

    // Driver: full frame; expected strobe content goes to the scoreboard queue.
    task automatic frame(input logic [1:0] a, input logic [CW-1:0] v,
                         input logic g0, input logic g1);
        logic [CW-1:0] rd;
        exp_q.push_back({a, v});
        pulse(1'b1);
        pulse(a[0]);
        pulse(a[1]);
        for (int i = 0; i < CW; i++) begin
            @(negedge clk);
            rd[i] = ser_dout;
            pulse(v[i]);
        end
        check("R4 readback", 64'(rd), 64'(model[a]));
        model[a] = v;
        pulse(g0);
        pulse(g1);
        @(negedge clk);
        check_codes("R2 R5 R9 codes");
    endtask

    task automatic deselect(input int cycles);
        ser_sel = 1'b0;
        repeat (cycles) @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: compares every strobe with the oldest expected frame.
    always @(negedge clk) begin
        if (rst_n && frame_done) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R5: strobe %0h with nothing expected", {frame_addr, frame_data});
            end else begin
                check("R5 strobe", 64'({frame_addr, frame_data}), 64'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        stored[0] = 8'h3C; stored[1] = 8'hA5; stored[2] = 8'h01; stored[3] = 8'hFE;
        for (int k = 0; k < NCH; k++) model[k] = stored[k];
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check_codes("R10 reset load");
        check("R3 idle enable", 64'(ser_dout_en), 64'd0);
        check("R3 idle dout", 64'(ser_dout), 64'd0);

        ser_sel = 1'b1;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check("R3 enable", 64'(ser_dout_en), 64'd1);

        // R1: leading zeros ignored, then each channel addressed (R2)
        pulse(1'b0); pulse(1'b0); pulse(1'b0);
        frame(2'b00, 8'h96, 1'b0, 1'b0);
        frame(2'b01, 8'h5B, 1'b0, 1'b0);
        frame(2'b10, 8'hE7, 1'b0, 1'b0);
        frame(2'b11, 8'h42, 1'b0, 1'b0);
        // R8: ones in the gap must not open a frame
        frame(2'b01, 8'hC8, 1'b1, 1'b1);
        pulse(1'b0);
        // R9: rewrite in arbitrary order
        frame(2'b11, 8'h00, 1'b0, 1'b0);
        frame(2'b00, 8'hFF, 1'b0, 1'b0);
        frame(2'b01, 8'h81, 1'b0, 1'b0);

        // R7: short glitch leaves temporary codes
        ser_sel = 1'b0;
        repeat (2) @(posedge clk);
        ser_sel = 1'b1;
        repeat (12) @(posedge clk);
        @(negedge clk);
        check_codes("R7 glitch ignored");

        // R6: real deselect reloads stored set
        deselect(20);
        for (int k = 0; k < NCH; k++) model[k] = stored[k];
        check_codes("R6 reload");
        check("R3 dout low", 64'(ser_dout), 64'd0);
        check("R3 enable low", 64'(ser_dout_en), 64'd0);
        ser_sel = 1'b1;
        repeat (10) @(posedge clk);

        // R11: abandon a frame mid-way
        pulse(1'b1); pulse(1'b0); pulse(1'b1); pulse(1'b1); pulse(1'b1); pulse(1'b1);
        deselect(20);
        check_codes("R11 abandon reload");
        ser_sel = 1'b1;
        repeat (10) @(posedge clk);
        frame(2'b10, 8'h6D, 1'b0, 1'b0);
        frame(2'b10, 8'h24, 1'b0, 1'b0);

        repeat (10) @(posedge clk);
        check("R5 queue drained", 64'(exp_q.size()), 64'd0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule